// File: doc/BRIEF.md
# Program Counter and Call/Return Sequencer

This block holds the 15-bit program counter of a small controller and works out where execution goes next. It takes a decoded control-flow operation with its immediate field, the accumulator and a byte from program ROM. It then updates the PC for straight-line advance, long and short absolute jumps, biased relative jumps and jumps through a ROM table. Subroutine calls, returns and a software interrupt exchange the return address with a stack that lives in byte-wide data memory. Each return address takes two bytes, so the 8-bit stack pointer moves by two on every call and every return.

Single-cycle operations update the PC at the clock edge that accepts them. Stack operations spend two further cycles on the memory port, one per byte, and raise `busy` during those cycles. An operation offered while `busy` is high is not accepted. Two return variants exist beside the plain return: one raises a one-cycle skip request so that the decoder drops the instruction at the restored address, and one sets the global interrupt enable.

Top module: `flow_sequencer`

## Requirements
- R1: While reset is low and after its release, `pc` is 0, `sp` is TOS_INIT (default 0xFF), and `gie`, `skip`, `busy`, `mem_we` and `mem_re` are 0.
- R2: An accepted NOP (op 0), and any op code from 11 to 15, sets `pc` to pc+1 modulo 2^15. A cycle with `op_valid` low leaves `pc` unchanged.
- R3: Long jump (op 1) loads `pc` with `imm[14:0]`.
- R4: Short jump (op 2) loads `pc[11:0]` from `imm[11:0]` and keeps `pc[14:12]`.
- R5: Relative jump (op 3) reads a 6-bit field `imm[5:0]` as the offset plus 31, covering −31 to +32, and sets `pc` to pc+offset modulo 2^15. The field value 32, which would mean +1, is not a real encoding; it gives pc+1.
- R6: A call (op 4 long target `imm[14:0]`, op 5 short target as in R4) stores the return address pc+1. In the first busy cycle it writes the low byte to address `sp`. In the second it writes `{0, ret[14:8]}` to address sp−1. After that `sp` is sp−2 and `pc` is the target.
- R7: A return (ops 7, 8, 9) reads address sp+2 in the first busy cycle and sp+1 in the second. It then loads `pc` with `{hi[6:0], lo}` and sets `sp` to sp+2.
- R8: After return-and-skip (op 8), `skip` is high for exactly the first cycle in which the restored PC is visible. No other operation raises `skip`.
- R9: Return-from-interrupt (op 9) sets `gie` to 1. `gie` then stays 1 until reset.
- R10: Software interrupt (op 6 is indirect, op 10 is interrupt) pushes pc+1 as in R6 and then loads `pc` with 0x0FF.
- R11: Indirect jump (op 6) drives `rom_addr` = `{pc[14:8], acc}` and replaces `pc[7:0]` with `rom_data`, keeping `pc[14:8]`.
- R12: Operations offered while `busy` is high are ignored: the PC is not changed by them. The stack pointer wraps modulo 256 without any indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is offered this cycle |
| op | input | 4 | Decoded control-flow operation code |
| imm | input | 15 | Immediate field (target, short target or biased offset) |
| acc | input | 8 | Accumulator value for the indirect jump |
| rom_addr | output | 15 | ROM byte address used by the indirect jump |
| rom_data | input | 8 | ROM byte at `rom_addr` (combinational) |
| mem_addr | output | 8 | Stack byte address in data memory |
| mem_wdata | output | 8 | Byte written to the stack |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_rdata | input | 8 | Byte read at `mem_addr` (combinational) |
| pc | output | 15 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Stack transfer in progress; fetch must stall |
| skip | output | 1 | Skip request after return-and-skip |
| gie | output | 1 | Global interrupt enable |

## Verification
The assertions assume that data memory answers a read in the same cycle, with `mem_rdata` valid at the address driven. The bench's memory model is a combinational array, so this always holds. They also assume that `op_valid` is a clean level sampled at the rising edge. The bench changes it only on falling edges and deliberately holds unrelated operations valid during busy cycles, so that the assertions see that such offers are dropped. Relative jumps sweep all 64 field values, and more than 128 nested calls drive the stack pointer round its wrap.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int unsigned PC_W    = 15;
  localparam int unsigned SP_W    = 8;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned SHORT_W = 12;
  localparam int unsigned REL_W   = 6;
  localparam int unsigned REL_BIAS = 31;
  localparam int unsigned HI_W    = PC_W - BYTE_W;
  localparam logic [PC_W-1:0] SWI_VECTOR = PC_W'(8'hFF);

  typedef enum logic [OP_W-1:0] {
    OP_NOP        = 4'd0,
    OP_JMP_LONG   = 4'd1,
    OP_JMP_SHORT  = 4'd2,
    OP_JMP_REL    = 4'd3,
    OP_CALL_LONG  = 4'd4,
    OP_CALL_SHORT = 4'd5,
    OP_JMP_IND    = 4'd6,
    OP_RET        = 4'd7,
    OP_RET_SKIP   = 4'd8,
    OP_RET_INT    = 4'd9,
    OP_SWI        = 4'd10
  } flow_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_LO, ST_WR_HI, ST_RD_LO, ST_RD_HI
  } stk_state_e;

  function automatic logic [PC_W-1:0] pc_inc(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] short_target(input logic [PC_W-1:0] p,
                                                   input logic [PC_W-1:0] i);
    return {p[PC_W-1:SHORT_W], i[SHORT_W-1:0]};
  endfunction

  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] p,
                                                 input logic [REL_W-1:0] f);
    return p + PC_W'(f) - PC_W'(REL_BIAS);
  endfunction

  function automatic logic [PC_W-1:0] rom_index(input logic [PC_W-1:0] p,
                                                input logic [BYTE_W-1:0] a);
    return {p[PC_W-1:BYTE_W], a};
  endfunction
endpackage

// File: rtl/flow_target.sv
module flow_target
  import flow_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   imm,
  input  logic [BYTE_W-1:0] acc,
  input  logic [BYTE_W-1:0] rom_data,
  output logic [PC_W-1:0]   rom_addr,
  output logic [PC_W-1:0]   jump_pc,
  output logic [PC_W-1:0]   call_pc,
  output logic              is_call,
  output logic              is_ret
);
  assign rom_addr = rom_index(pc, acc);

  always_comb begin
    jump_pc = pc_inc(pc);
    call_pc = imm;
    is_call = 1'b0;
    is_ret  = 1'b0;
    case (flow_op_e'(op))
      OP_JMP_LONG:   jump_pc = imm;
      OP_JMP_SHORT:  jump_pc = short_target(pc, imm);
      OP_JMP_REL:    jump_pc = rel_target(pc, imm[REL_W-1:0]);
      OP_JMP_IND:    jump_pc = {pc[PC_W-1:BYTE_W], rom_data};
      OP_CALL_LONG:  begin is_call = 1'b1; call_pc = imm; end
      OP_CALL_SHORT: begin is_call = 1'b1; call_pc = short_target(pc, imm); end
      OP_SWI:        begin is_call = 1'b1; call_pc = SWI_VECTOR; end
      OP_RET, OP_RET_SKIP, OP_RET_INT: is_ret = 1'b1;
      default:       jump_pc = pc_inc(pc);
    endcase
  end
endmodule

// File: rtl/flow_stack.sv
module flow_stack
  import flow_pkg::*;
#(
  parameter logic [SP_W-1:0] TOS_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_push,
  input  logic              start_pop,
  input  logic [PC_W-1:0]   ret_in,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [SP_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [SP_W-1:0]   sp,
  output logic              busy,
  output logic              push_done,
  output logic              pop_done,
  output logic [PC_W-1:0]   pop_pc
);
  stk_state_e        state;
  logic [PC_W-1:0]   ret_q;
  logic [BYTE_W-1:0] lo_q;

  assign busy      = (state != ST_IDLE);
  assign push_done = (state == ST_WR_HI);
  assign pop_done  = (state == ST_RD_HI);
  assign pop_pc    = {mem_rdata[HI_W-1:0], lo_q};

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    case (state)
      ST_WR_LO: begin mem_we = 1'b1; mem_addr = sp;
                      mem_wdata = ret_q[BYTE_W-1:0]; end
      ST_WR_HI: begin mem_we = 1'b1; mem_addr = sp - SP_W'(1);
                      mem_wdata = BYTE_W'(ret_q[PC_W-1:BYTE_W]); end
      ST_RD_LO: begin mem_re = 1'b1; mem_addr = sp + SP_W'(2); end
      ST_RD_HI: begin mem_re = 1'b1; mem_addr = sp + SP_W'(1); end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sp    <= TOS_INIT;
      ret_q <= '0;
      lo_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_push) begin
            state <= ST_WR_LO;
            ret_q <= ret_in;
          end else if (start_pop) begin
            state <= ST_RD_LO;
          end
        end
        ST_WR_LO: state <= ST_WR_HI;
        ST_WR_HI: begin state <= ST_IDLE; sp <= sp - SP_W'(2); end
        ST_RD_LO: begin state <= ST_RD_HI; lo_q <= mem_rdata; end
        ST_RD_HI: begin state <= ST_IDLE; sp <= sp + SP_W'(2); end
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
  import flow_pkg::*;
#(
  parameter logic [SP_W-1:0] TOS_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [PC_W-1:0]   imm,
  input  logic [BYTE_W-1:0] acc,
  output logic [PC_W-1:0]   rom_addr,
  input  logic [BYTE_W-1:0] rom_data,
  output logic [SP_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic              busy,
  output logic              skip,
  output logic              gie
);
  logic [PC_W-1:0] jump_pc, call_pc, pop_pc, tgt_q;
  logic            is_call, is_ret;
  logic            ev_accept, ev_jump, ev_push, ev_pop;
  logic            push_done, pop_done;
  logic            want_skip_q, want_gie_q;

  assign ev_accept = op_valid && !busy;
  assign ev_push   = ev_accept && is_call;
  assign ev_pop    = ev_accept && is_ret;
  assign ev_jump   = ev_accept && !is_call && !is_ret;

  flow_target u_target (
    .op(op), .pc(pc), .imm(imm), .acc(acc), .rom_data(rom_data),
    .rom_addr(rom_addr), .jump_pc(jump_pc), .call_pc(call_pc),
    .is_call(is_call), .is_ret(is_ret)
  );

  flow_stack #(.TOS_INIT(TOS_INIT)) u_stack (
    .clk(clk), .rst_n(rst_n), .start_push(ev_push), .start_pop(ev_pop),
    .ret_in(pc_inc(pc)), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .sp(sp),
    .busy(busy), .push_done(push_done), .pop_done(pop_done), .pop_pc(pop_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc          <= '0;
      tgt_q       <= '0;
      want_skip_q <= 1'b0;
      want_gie_q  <= 1'b0;
      skip        <= 1'b0;
      gie         <= 1'b0;
    end else begin
      if (ev_jump)        pc <= jump_pc;
      else if (push_done) pc <= tgt_q;
      else if (pop_done)  pc <= pop_pc;
      if (ev_push) tgt_q <= call_pc;
      if (ev_pop) begin
        want_skip_q <= (flow_op_e'(op) == OP_RET_SKIP);
        want_gie_q  <= (flow_op_e'(op) == OP_RET_INT);
      end
      skip <= pop_done && want_skip_q;
      if (pop_done && want_gie_q) gie <= 1'b1;
    end
  end
endmodule

// File: rtl/flow_sequencer_chk.sv
module flow_sequencer_chk
  import flow_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ev_push,
  input logic            push_done,
  input logic            pop_done,
  input logic            busy,
  input logic            mem_we,
  input logic            mem_re,
  input logic [SP_W-1:0] mem_addr,
  input logic [SP_W-1:0] sp,
  input logic [PC_W-1:0] pc,
  input logic            skip,
  input logic            gie
);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));
  p_busy_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_we || mem_re));
  p_call_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> (mem_we && mem_addr == $past(sp)));
  p_push_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |=> (sp == $past(sp) - SP_W'(2)));
  p_pop_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done |=> (sp == $past(sp) + SP_W'(2)));
  p_skip_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> $past(pop_done));
  p_gie_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(gie));
  p_hold_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !push_done && !pop_done) |=> $stable(pc));
endmodule

bind flow_sequencer flow_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_push(ev_push), .push_done(push_done),
  .pop_done(pop_done), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .sp(sp), .pc(pc), .skip(skip), .gie(gie)
);

// File: tb/flow_sequencer_tb.sv
module flow_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [14:0] imm = '0;
  logic [7:0]  acc = '0;
  logic [14:0] rom_addr;
  logic [7:0]  rom_data;
  logic [7:0]  mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, mem_re;
  logic [14:0] pc;
  logic [7:0]  sp;
  logic        busy, skip, gie;

  logic [7:0]  mem [0:255];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [14:0] exp_pc = '0;
  logic [7:0]  exp_sp = 8'hFF;
  logic [14:0] rstack [0:511];
  int          depth = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .imm(imm),
    .acc(acc), .rom_addr(rom_addr), .rom_data(rom_data), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .busy(busy), .skip(skip), .gie(gie)
  );

  // ROM model: an arithmetic pattern of the address.
  assign rom_data  = rom_addr[7:0] * 8'd3 ^ {1'b0, rom_addr[14:8]};
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic single(input logic [3:0] o, input logic [14:0] i, input string req);
    @(negedge clk); op_valid = 1'b1; op = o; imm = i;
    @(negedge clk); op_valid = 1'b0;
    check(pc == exp_pc, req, pc, exp_pc);
  endtask

  task automatic jump_long(input logic [14:0] t);
    exp_pc = t;
    single(4'd1, t, "R3");
  endtask

  task automatic do_call(input logic [3:0] o, input logic [14:0] i, input logic [14:0] tgt,
                         input string req);
    logic [14:0] r;
    r = exp_pc + 15'd1;
    @(negedge clk); op_valid = 1'b1; op = o; imm = i;
    @(negedge clk);
    op = 4'd1; imm = 15'h5A5A;              // R12: offered while busy
    check(busy && mem_we && mem_addr == exp_sp && mem_wdata == r[7:0], req,
          {busy, mem_we, mem_addr, mem_wdata}, {2'b11, exp_sp, r[7:0]});
    @(negedge clk);
    check(mem_we && mem_addr == exp_sp - 8'd1 && mem_wdata == {1'b0, r[14:8]}, req,
          {mem_we, mem_addr, mem_wdata}, {1'b1, exp_sp - 8'd1, 1'b0, r[14:8]});
    check(pc == exp_pc, "R12", pc, exp_pc);
    @(negedge clk); op_valid = 1'b0;
    exp_sp = exp_sp - 8'd2; exp_pc = tgt;
    rstack[depth] = r; depth++;
    check(!busy && pc == exp_pc && sp == exp_sp, req, {busy, pc, sp}, {1'b0, exp_pc, exp_sp});
  endtask

  task automatic do_ret(input logic [3:0] o, input string req);
    @(negedge clk); op_valid = 1'b1; op = o;
    @(negedge clk);
    op = 4'd0;                              // R12: NOP offered while busy
    check(busy && mem_re && mem_addr == exp_sp + 8'd2, req,
          {busy, mem_re, mem_addr}, {2'b11, exp_sp + 8'd2});
    @(negedge clk);
    check(mem_re && mem_addr == exp_sp + 8'd1, req, {mem_re, mem_addr}, {1'b1, exp_sp + 8'd1});
    @(negedge clk); op_valid = 1'b0;
    depth--; exp_pc = rstack[depth]; exp_sp = exp_sp + 8'd2;
    check(pc == exp_pc && sp == exp_sp, req, {pc, sp}, {exp_pc, exp_sp});
    check(skip == (o == 4'd8), "R8", skip, o == 4'd8);
    @(negedge clk);
    check(!skip, "R8", skip, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    check(pc == 0 && sp == 8'hFF && !gie && !skip && !busy && !mem_we && !mem_re, "R1",
          {pc, sp, gie, skip, busy, mem_we, mem_re}, {15'd0, 8'hFF, 5'd0});
    rst_n = 1'b1;
    @(negedge clk);
    check(pc == 0 && sp == 8'hFF && !busy, "R1", {pc, sp}, {15'd0, 8'hFF});

    // R2: advance, hold, unused codes
    exp_pc = 15'd1; single(4'd0, 15'd0, "R2");
    repeat (3) @(negedge clk);
    check(pc == exp_pc, "R2 hold", pc, exp_pc);
    for (int c = 11; c < 16; c++) begin
      exp_pc = exp_pc + 15'd1; single(4'(c), 15'h1234, "R2");
    end
    jump_long(15'h7FFF);
    exp_pc = 15'd0; single(4'd0, 15'd0, "R2 wrap");

    // R3: walking targets
    for (int b = 0; b < 15; b++) jump_long(15'(1 << b));

    // R4: short jumps keep top three bits
    for (int u = 0; u < 8; u++) begin
      jump_long({3'(u), 12'hABC});
      exp_pc = {3'(u), 12'(u * 517 + 3)};
      single(4'd2, {3'(7 - u), 12'(u * 517 + 3)}, "R4");
    end

    // R5: every offset field, including the excluded +1 code
    for (int f = 0; f < 64; f++) begin
      jump_long(15'h4010);
      exp_pc = 15'(15'h4010 + f - 31);
      single(4'd3, 15'(f), "R5");
    end
    jump_long(15'd3);
    exp_pc = 15'(3 - 31);
    single(4'd3, 15'd0, "R5 wrap");

    // R11: indirect through ROM
    for (int a = 0; a < 8; a++) begin
      jump_long(15'(a * 4111));
      acc = 8'(a * 37 + 5);
      exp_pc = {exp_pc[14:8], 8'(8'(a * 37 + 5) * 8'd3 ^ {1'b0, exp_pc[14:8]})};
      single(4'd6, 15'd0, "R11");
    end

    // R6/R7: nested calls and returns
    jump_long(15'h1230);
    do_call(4'd4, 15'h6001, 15'h6001, "R6");
    do_call(4'd5, 15'h0456, 15'h6456, "R6");
    do_call(4'd4, 15'h7F00, 15'h7F00, "R6");
    do_ret(4'd7, "R7");
    do_ret(4'd8, "R8");
    check(gie == 1'b0, "R9", gie, 0);
    do_ret(4'd9, "R9");
    check(gie == 1'b1, "R9", gie, 1);

    // R10: software interrupt
    jump_long(15'h2222);
    do_call(4'd10, 15'h0000, 15'h00FF, "R10");
    do_ret(4'd7, "R10");
    check(gie == 1'b1, "R9 sticky", gie, 1);

    // R12: stack pointer wrap
    for (int n = 0; n < 130; n++) do_call(4'd4, 15'(n * 97 + 11), 15'(n * 97 + 11), "R12");
    check(sp == 8'(8'hFF - 8'd4), "R12 wrap", sp, 8'hFB);
    for (int n = 0; n < 3; n++) do_ret(4'd7, "R12");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule